// File: doc/BRIEF.md
# Dual-Clock Queue with Fall-Through Output Stage

This block moves a stream of data words from one clock domain to another while keeping their order. Storage is a circular buffer whose size is a power of two, addressed by read and write counters that carry one extra wrap bit. Each counter is Gray-coded and passed into the other domain through a two-stage synchronizer. On the read side, a single output register sits after the buffer. It pulls the oldest stored word as soon as it has room, so the word at the head of the queue is always on `r_data` whenever `r_rdy` is high.

Because of that output register, the total capacity is a power of two plus one. A requested depth is rounded up to that form. When the `EXACT_DEPTH` parameter is set, a depth that is not already of that form stops elaboration with an error. Each side reports its own fill level, computed from the values it can see in its own domain.

Top module: `dual_clock_queue`

## Requirements
- R1: The number of words the queue accepts with no reads is 0 when `REQ_DEPTH` is 0. Otherwise it is one more than the smallest power of two that is at least max(`REQ_DEPTH`-1, 1). For requests 1, 2, 3, 4, 16 and 18 this gives 2, 2, 3, 5, 17 and 33.
- R2: Words leave the read port in exactly the order they were accepted, for any ratio between the two clocks.
- R3: `w_rdy` goes low once the queue holds its full capacity. A write offered while `w_rdy` is low is dropped and never appears at the read port.
- R4: While `r_rdy` is high, `r_data` shows the oldest stored word, and it holds that value until a read (`r_en` high with `r_rdy` high) takes it.
- R5: `w_level` rises by one at the write clock edge that accepts a write. Once both sides are idle, it settles to the number of stored words and never exceeds the capacity.
- R6: Once both sides are idle, `r_level` settles to the number of stored words. It never exceeds the capacity.
- R7: Raising either `w_rst` or `r_rst` empties the queue. While `w_rst` is high, `r_rdy` stays low. After release, both levels read 0 and the words written before the reset are gone.
- R8: `w_rdy` is low while a reset is applied, and it returns high within a few write clock cycles after release.
- R9: A read request made while `r_rdy` is low has no effect on the level or on the data read later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| w_clk | input | 1 | Write-side clock |
| w_rst | input | 1 | Write-side reset, active high, asynchronous assertion |
| w_en | input | 1 | Write request |
| w_data | input | WIDTH | Word to enqueue |
| w_rdy | output | 1 | Queue can take a word this write cycle |
| w_level | output | LW | Fill level seen from the write domain |
| r_clk | input | 1 | Read-side clock |
| r_rst | input | 1 | Read-side reset, active high, asynchronous assertion |
| r_en | input | 1 | Read request (takes the word on `r_data`) |
| r_data | output | WIDTH | Word at the head of the queue |
| r_rdy | output | 1 | `r_data` holds a valid word |
| r_level | output | LW | Fill level seen from the read domain |

## Verification
The assertions assume three things about the inputs. Each clock toggles only while its inputs are stable away from its rising edge. Resets are raised only between edges. The data on `r_data` is treated as settled only after the reset synchronizers have released. The stimulus changes every input on the falling edge of its own clock. It raises resets only on a falling write edge, and it waits for both levels to stop moving before it compares levels against counts. This is needed because levels in the two domains agree only after the synchronizer delays have passed.

// File: rtl/dcq_pkg.sv
package dcq_pkg;

  function automatic int unsigned ceil_pow2(int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 31; i++) begin
      if (p < n) p = p << 1;
    end
    return p;
  endfunction

  // Buffer entries behind the output register.
  function automatic int unsigned core_depth(int unsigned req);
    if (req == 0) return 0;
    return ceil_pow2((req > 1) ? req - 1 : 1);
  endfunction

  // Total words held, output register included.
  function automatic int unsigned total_depth(int unsigned req);
    return (req == 0) ? 0 : core_depth(req) + 1;
  endfunction

  function automatic int unsigned level_width(int unsigned req);
    int unsigned w;
    w = $clog2(total_depth(req) + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/dcq_sync.sv
module dcq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= INIT;
      q      <= INIT;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcq_core.sv
module dcq_core #(
  parameter int WIDTH = 8,
  parameter int CORE  = 4
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             w_req,
  input  logic [WIDTH-1:0] w_data,
  output logic             w_full,
  output logic [$clog2(CORE):0] w_occ,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             r_req,
  output logic [WIDTH-1:0] r_data,
  output logic             r_empty,
  output logic [$clog2(CORE):0] r_occ
);
  localparam int PW = $clog2(CORE) + 1;
  localparam int AW = (CORE > 1) ? $clog2(CORE) : 1;
  localparam logic [PW-1:0] FULLV = PW'(CORE);

  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIDTH-1:0] mem [2**AW];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rgray_at_w, wgray_at_r;
  logic          w_push, r_pop;

  // Write domain
  assign w_occ  = wbin - from_gray(rgray_at_w);
  assign w_full = (w_occ == FULLV);
  assign w_push = w_req & ~w_full;

  always_ff @(posedge wclk or posedge wrst) begin
    if (wrst) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (w_push) begin
      wbin  <= wbin + 1'b1;
      wgray <= to_gray(wbin + 1'b1);
    end
  end

  always_ff @(posedge wclk) begin
    if (w_push) mem[wbin[AW-1:0]] <= w_data;
  end

  dcq_sync #(.W(PW)) u_r2w (.clk(wclk), .arst(wrst), .d(rgray), .q(rgray_at_w));

  // Read domain
  assign r_occ   = from_gray(wgray_at_r) - rbin;
  assign r_empty = (r_occ == '0);
  assign r_pop   = r_req & ~r_empty;
  assign r_data  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or posedge rrst) begin
    if (rrst) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (r_pop) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  dcq_sync #(.W(PW)) u_w2r (.clk(rclk), .arst(rrst), .d(wgray), .q(wgray_at_r));

  AST_WRITE_BOUND: assert property (@(posedge wclk) disable iff (wrst)
    w_occ <= FULLV) else $error("write-side occupancy over capacity"); // R3
  AST_READ_BOUND: assert property (@(posedge rclk) disable iff (rrst)
    r_occ <= FULLV) else $error("read-side occupancy over capacity"); // R6
  AST_GRAY_STEP: assert property (@(posedge wclk) disable iff (wrst)
    $countones(wgray ^ $past(wgray)) <= 1) else $error("write pointer moved by more than one code bit"); // R2
endmodule

// File: rtl/dcq_outreg.sv
module dcq_outreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_empty,
  input  logic [WIDTH-1:0] src_data,
  output logic             src_take,
  input  logic             take,
  output logic             valid,
  output logic [WIDTH-1:0] data
);
  logic drained;

  assign drained  = valid & take;
  assign src_take = ~src_empty & (~valid | drained);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           valid <= 1'b0;
    else if (src_take) valid <= 1'b1;
    else if (drained)  valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (src_take) data <= src_data;
  end

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && !take) |=> (valid && $stable(data))) else $error("head word changed without a read"); // R4
endmodule

// File: rtl/dual_clock_queue.sv
module dual_clock_queue #(
  parameter int WIDTH       = 8,
  parameter int REQ_DEPTH   = 4,
  parameter bit EXACT_DEPTH = 1'b0,
  localparam int LW = dcq_pkg::level_width(REQ_DEPTH)
) (
  input  logic             w_clk,
  input  logic             w_rst,
  input  logic             w_en,
  input  logic [WIDTH-1:0] w_data,
  output logic             w_rdy,
  output logic [LW-1:0]    w_level,
  input  logic             r_clk,
  input  logic             r_rst,
  input  logic             r_en,
  output logic [WIDTH-1:0] r_data,
  output logic             r_rdy,
  output logic [LW-1:0]    r_level
);
  localparam int CORE  = dcq_pkg::core_depth(REQ_DEPTH);
  localparam int TOTAL = dcq_pkg::total_depth(REQ_DEPTH);

  if (EXACT_DEPTH && TOTAL != REQ_DEPTH) begin : g_depth_reject
    $error("requested depth is not one more than a power of two");
  end

  if (TOTAL == 0) begin : g_empty
    logic unused_inputs;
    assign unused_inputs = ^{w_clk, w_rst, w_en, w_data, r_clk, r_rst, r_en};
    assign w_rdy   = 1'b0;
    assign w_level = '0;
    assign r_rdy   = 1'b0;
    assign r_data  = '0;
    assign r_level = '0;
  end else begin : g_queue
    localparam int PW = $clog2(CORE) + 1;

    logic             any_rst, w_rst_i, r_rst_i;
    logic             core_full, core_empty, core_take, head_valid, head_at_w;
    logic [PW-1:0]    w_occ, r_occ;
    logic [WIDTH-1:0] core_data;

    // Either reset clears both sides; release is synchronized per domain.
    assign any_rst = w_rst | r_rst;
    dcq_sync #(.W(1), .INIT(1'b1)) u_wrs (.clk(w_clk), .arst(any_rst), .d(1'b0), .q(w_rst_i));
    dcq_sync #(.W(1), .INIT(1'b1)) u_rrs (.clk(r_clk), .arst(any_rst), .d(1'b0), .q(r_rst_i));

    dcq_core #(.WIDTH(WIDTH), .CORE(CORE)) u_core (
      .wclk(w_clk), .wrst(w_rst_i), .w_req(w_en & ~w_rst_i), .w_data(w_data),
      .w_full(core_full), .w_occ(w_occ),
      .rclk(r_clk), .rrst(r_rst_i), .r_req(core_take), .r_data(core_data),
      .r_empty(core_empty), .r_occ(r_occ)
    );

    dcq_outreg #(.WIDTH(WIDTH)) u_head (
      .clk(r_clk), .rst(r_rst_i), .src_empty(core_empty), .src_data(core_data),
      .src_take(core_take), .take(r_en), .valid(head_valid), .data(r_data)
    );

    dcq_sync #(.W(1)) u_head_w (.clk(w_clk), .arst(w_rst_i), .d(head_valid), .q(head_at_w));

    assign r_rdy   = head_valid;
    assign r_level = LW'(r_occ) + LW'(head_valid);
    assign w_rdy   = ~core_full & ~w_rst_i;
    assign w_level = LW'(w_occ) + LW'(head_at_w);

    AST_WLEVEL_CAP: assert property (@(posedge w_clk) disable iff (w_rst_i)
      w_level <= LW'(TOTAL)) else $error("write level above capacity"); // R5
    AST_RLEVEL_CAP: assert property (@(posedge r_clk) disable iff (r_rst_i)
      r_level <= LW'(TOTAL)) else $error("read level above capacity"); // R6
    AST_RST_QUIET: assert property (@(posedge r_clk) disable iff (r_rst)
      w_rst |-> !r_rdy) else $error("read ready during write reset"); // R7
    AST_RST_NO_WRITE: assert property (@(posedge w_clk) disable iff (1'b0)
      any_rst |-> !w_rdy) else $error("write ready during reset"); // R8
  end
endmodule

// File: tb/tb_dual_clock_queue.sv
`timescale 1ns/1ps
module tb_dual_clock_queue;
  localparam int CAPN = 7;

  function automatic int cap_req(int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 4;  5: return 16; default: return 18;
    endcase
  endfunction

  function automatic int cap_expect(int i);
    case (i)
      0: return 0;  1: return 2;  2: return 2;  3: return 3;
      4: return 5;  5: return 17; default: return 33;
    endcase
  endfunction

  logic w_clk = 1'b0, r_clk = 1'b0;
  real  rhalf = 7.0;
  always #5 w_clk = ~w_clk;
  always #(rhalf) r_clk = ~r_clk;

  logic       w_rst = 1'b0, r_rst = 1'b0;
  logic       w_en = 1'b0, r_en = 1'b0;
  logic [7:0] w_data = '0;
  logic       w_rdy, r_rdy;
  logic [7:0] r_data;
  logic [2:0] w_level, r_level;

  dual_clock_queue #(.WIDTH(8), .REQ_DEPTH(4), .EXACT_DEPTH(1'b0)) dut (
    .w_clk(w_clk), .w_rst(w_rst), .w_en(w_en), .w_data(w_data), .w_rdy(w_rdy), .w_level(w_level),
    .r_clk(r_clk), .r_rst(r_rst), .r_en(r_en), .r_data(r_data), .r_rdy(r_rdy), .r_level(r_level)
  );

  // Capacity sweep over several requested depths
  logic cap_wen = 1'b0;
  int   cap_acc  [CAPN];
  int   cap_rlev [CAPN];
  int   cap_wlev [CAPN];

  for (genvar i = 0; i < CAPN; i++) begin : g_cap
    localparam int EXP = cap_expect(i);
    localparam int LWI = (EXP == 0) ? 1 : $clog2(EXP + 1);
    logic           rdy_w, rdy_r;
    logic [7:0]     rdat;
    logic [LWI-1:0] lw, lr;
    int             acc = 0;
    dual_clock_queue #(.WIDTH(8), .REQ_DEPTH(cap_req(i)), .EXACT_DEPTH(1'b0)) u_cap (
      .w_clk(w_clk), .w_rst(w_rst), .w_en(cap_wen), .w_data(8'h00), .w_rdy(rdy_w), .w_level(lw),
      .r_clk(r_clk), .r_rst(r_rst), .r_en(1'b0), .r_data(rdat), .r_rdy(rdy_r), .r_level(lr)
    );
    always @(negedge w_clk) begin
      if (w_rst) acc = 0;
      else if (cap_wen && rdy_w) acc = acc + 1;
    end
    assign cap_acc[i]  = acc;
    assign cap_rlev[i] = int'(lr);
    assign cap_wlev[i] = int'(lw);
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge w_clk);
    repeat (8) @(negedge r_clk);
  endtask

  task automatic wr_word(input logic [7:0] d);
    bit acc;
    @(negedge w_clk);
    w_en = 1'b1; w_data = d;
    forever begin
      acc = w_rdy;
      @(negedge w_clk);
      if (acc) break;
    end
    w_en = 1'b0;
  endtask

  task automatic rd_word(output logic [7:0] d);
    bit acc;
    @(negedge r_clk);
    r_en = 1'b1;
    forever begin
      acc = r_rdy; d = r_data;
      @(negedge r_clk);
      if (acc) break;
    end
    r_en = 1'b0;
  endtask

  function automatic logic [7:0] pat(int phase, int k);
    return 8'((k * 7 + phase * 41 + 3) & 255);
  endfunction

  task automatic stream(input int phase, input int n);
    fork
      begin
        for (int k = 0; k < n; k++) begin
          repeat ($urandom % 3) @(negedge w_clk);
          wr_word(pat(phase, k));
        end
      end
      begin
        logic [7:0] d;
        for (int j = 0; j < n; j++) begin
          repeat ($urandom % 3) @(negedge r_clk);
          rd_word(d);
          chk("R2 order", int'(d), int'(pat(phase, j)));
        end
      end
    join
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge w_clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int acc;
    #1; w_rst = 1'b1; r_rst = 1'b1;
    repeat (3) @(negedge w_clk);
    chk("R8 w_rdy in reset", int'(w_rdy), 0);
    chk("R7 r_rdy in reset", int'(r_rdy), 0);
    chk("R7 w_level in reset", int'(w_level), 0);
    chk("R7 r_level in reset", int'(r_level), 0);
    w_rst = 1'b0; r_rst = 1'b0;
    settle();
    chk("R8 w_rdy after release", int'(w_rdy), 1);

    // R1 capacity sweep, no reads
    @(negedge w_clk); cap_wen = 1'b1;
    repeat (100) @(negedge w_clk);
    cap_wen = 1'b0;
    settle();
    for (int i = 0; i < CAPN; i++) begin
      chk($sformatf("R1 accepted for request %0d", cap_req(i)), cap_acc[i], cap_expect(i));
      chk($sformatf("R1 r_level for request %0d", cap_req(i)), cap_rlev[i], cap_expect(i));
      chk($sformatf("R1 w_level for request %0d", cap_req(i)), cap_wlev[i], cap_expect(i));
    end

    // R5/R6/R4 single word
    wr_word(8'h3C);
    chk("R5 w_level after one write", int'(w_level), 1);
    settle();
    chk("R4 r_rdy with one word", int'(r_rdy), 1);
    chk("R4 head data", int'(r_data), 'h3C);
    chk("R6 r_level one word", int'(r_level), 1);
    chk("R5 w_level settled", int'(w_level), 1);
    repeat (4) @(negedge r_clk);
    chk("R4 head held", int'(r_data), 'h3C);
    rd_word(d);
    chk("R4 read value", int'(d), 'h3C);
    settle();
    chk("R6 r_level empty", int'(r_level), 0);
    chk("R5 w_level empty", int'(w_level), 0);
    chk("R4 r_rdy empty", int'(r_rdy), 0);

    // R9 read on empty
    @(negedge r_clk); r_en = 1'b1;
    repeat (4) @(negedge r_clk);
    r_en = 1'b0;
    chk("R9 r_level after empty read", int'(r_level), 0);
    wr_word(8'hA5);
    settle();
    chk("R9 r_level after write", int'(r_level), 1);
    rd_word(d);
    chk("R9 data after empty read", int'(d), 'hA5);
    settle();

    // R3 fill to capacity, extra writes dropped
    acc = 0;
    @(negedge w_clk); w_en = 1'b1;
    for (int c = 0; c < 30; c++) begin
      bit ok;
      w_data = 8'(8'h10 + acc);
      ok = w_rdy;
      @(negedge w_clk);
      if (ok) acc++;
    end
    w_data = 8'hEE;
    w_en = 1'b0;
    chk("R3 accepted count", acc, 5);
    chk("R3 w_rdy when full", int'(w_rdy), 0);
    settle();
    chk("R5 w_level full", int'(w_level), 5);
    chk("R6 r_level full", int'(r_level), 5);
    for (int j = 0; j < 5; j++) begin
      rd_word(d);
      chk("R3 drained value", int'(d), 'h10 + j);
    end
    settle();
    chk("R3 nothing beyond capacity", int'(r_rdy), 0);
    chk("R3 level after drain", int'(r_level), 0);

    // R2 streams at several clock ratios
    rhalf = 2.0;  repeat (4) @(negedge r_clk); stream(0, 100);
    rhalf = 13.0; repeat (4) @(negedge r_clk); stream(1, 80);
    rhalf = 5.0;  repeat (4) @(negedge r_clk); stream(2, 100);
    settle();

    // R7 write-side reset with data stored
    wr_word(8'h01); wr_word(8'h02); wr_word(8'h03);
    settle();
    @(negedge w_clk); w_rst = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge r_clk);
      chk("R7 r_rdy while w_rst", int'(r_rdy), 0);
    end
    @(negedge w_clk); w_rst = 1'b0;
    settle();
    chk("R7 r_level after w_rst", int'(r_level), 0);
    chk("R7 w_level after w_rst", int'(w_level), 0);
    chk("R8 w_rdy after w_rst", int'(w_rdy), 1);
    wr_word(8'h77);
    rd_word(d);
    chk("R7 old words gone", int'(d), 'h77);
    settle();

    // R7 read-side reset
    wr_word(8'h21); wr_word(8'h22);
    settle();
    @(negedge r_clk); r_rst = 1'b1;
    repeat (3) @(negedge r_clk);
    r_rst = 1'b0;
    settle();
    chk("R7 r_level after r_rst", int'(r_level), 0);
    chk("R7 w_level after r_rst", int'(w_level), 0);
    chk("R7 r_rdy after r_rst", int'(r_rdy), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule